// File: doc/BRIEF.md
# Configuration Access Address Translator

This block sits between a configuration-space requester and the outbound access path of a root port. A request names a bus, a device, a function and a register offset, and says whether it is a read or a write. The block decides whether the request stays in the root port's own register space or goes downstream. It picks the configuration cycle type and builds the downstream target word. It aligns the offset to a whole 32-bit register and drops requests for devices that cannot exist behind the port.

A request is taken with a valid/ready handshake, and only one request is in flight at a time. Accepted requests that pass the device filter appear on the access side, which stays asserted until the transport reports completion. Filtered requests never reach the access side and are answered at once. Every request ends with a single-cycle response that carries read data and an error flag.

Top module: `cfgx_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and both `acc_valid` and `rsp_valid` are 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from acceptance until the edge after the response cycle. `rsp_valid` is high for exactly one cycle per accepted request.
- R3: The access type is 4 (type-0 configuration cycle) for buses 0 and 1, and 5 (type-1 cycle) for every higher bus.
- R4: Bus 0 accesses set `acc_local`=1 with `acc_target`=0. Any other bus sets `acc_local`=0 with `acc_target` = bus in bits 31:24, device in bits 23:19, function in bits 18:16 and zeros in bits 15:0.
- R5: `acc_offset` is the request offset with bits 1:0 cleared.
- R6: On bus 0 only devices 0 and 1 exist. On bus 1 only device 0 exists. On buses 2 to 255 every device number is accepted.
- R7: A read of a device that does not exist produces no access. Its response comes in the cycle after acceptance with data 0xFFFFFFFF and `rsp_err`=0.
- R8: A write to a device that does not exist produces no access. Its response comes in the cycle after acceptance with `rsp_err`=1 and data 0.
- R9: A surviving request raises `acc_valid` in the cycle after acceptance. Its fields hold steady until the edge where `acc_done` is 1. The response follows in the next cycle, carrying `acc_rdata` for reads, data 0 for writes, and `rsp_err`=0 when `acc_abort` is 0.
- R10: If `acc_abort` is 1 together with `acc_done`, a read answers 0xFFFFFFFF with `rsp_err`=0, and a write answers data 0 with `rsp_err`=1.
- R11: `acc_write` and `acc_wdata` carry the request's direction and write data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_offset | input | 12 | Register byte offset |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| acc_valid | output | 1 | Translated access pending |
| acc_local | output | 1 | Access targets the root port's own registers |
| acc_type | output | 3 | Configuration cycle type code |
| acc_target | output | 32 | Downstream target word |
| acc_offset | output | 12 | Aligned register offset |
| acc_write | output | 1 | Access direction |
| acc_wdata | output | 32 | Access write data |
| acc_done | input | 1 | Transport finished the access |
| acc_rdata | input | 32 | Read data from transport |
| acc_abort | input | 1 | Transport aborted the access |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_rdata | output | 32 | Response data |
| rsp_err | output | 1 | Response error |

## Verification
A filtered request answers in the first cycle after the accepting edge. A surviving request shows its access in that same cycle, and its response comes one cycle after the edge that samples `acc_done`. The response therefore lands at acceptance plus one plus the transport delay. The scoreboard stamps each expected response with that cycle number. The monitor compares the stamp against a free-running cycle count on the falling edge, so a response that comes early, comes late or repeats is reported. The transport model checks each access on the falling edge when it first appears and again on the completion cycle, which covers field stability over varying delays.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

   typedef enum logic [1:0] {
      CX_IDLE = 2'd0,
      CX_WAIT = 2'd1,
      CX_RESP = 2'd2
   } cfgx_state_e;

endpackage

// File: rtl/cfgx_decode.sv
module cfgx_decode #(
   parameter int BUS_W            = 8,
   parameter int DEV_W            = 5,
   parameter int FUNC_W           = 3,
   parameter int OFF_W            = 12,
   parameter int TGT_W            = 32,
   parameter int ALIGN            = 2,
   parameter int TYPE_W           = 3,
   parameter int TYPE_NEAR        = 4,
   parameter int TYPE_FAR         = 5,
   parameter int LOCAL_BUS        = 0,
   parameter int NEAR_LAST_BUS    = 1,
   parameter int LOCAL_DEV_MAX    = 1,
   parameter int FIRST_DS_DEV_MAX = 0
) (
   input  logic [BUS_W-1:0]  bus,
   input  logic [DEV_W-1:0]  dev,
   input  logic [FUNC_W-1:0] func,
   input  logic [OFF_W-1:0]  off,
   output logic              dev_ok,
   output logic              is_local,
   output logic [TYPE_W-1:0] cfg_type,
   output logic [TGT_W-1:0]  target,
   output logic [OFF_W-1:0]  off_al
);

   localparam int BDF_W = BUS_W + DEV_W + FUNC_W;
   localparam int PAD_W = TGT_W - BDF_W;
   localparam logic [OFF_W-1:0] LOW_MASK = (OFF_W'(1) << ALIGN) - OFF_W'(1);

   logic [BDF_W-1:0] bdf;
   logic [TGT_W-1:0] packed_tgt;

   assign bdf = {bus, dev, func};

   generate
      if (PAD_W > 0) begin : g_pad
         assign packed_tgt = {bdf, {PAD_W{1'b0}}};
      end else begin : g_nopad
         assign packed_tgt = bdf;
      end
   endgenerate

   always_comb begin
      if (bus == BUS_W'(LOCAL_BUS)) begin
         dev_ok = (dev <= DEV_W'(LOCAL_DEV_MAX));
      end else if (bus == BUS_W'(LOCAL_BUS + 1)) begin
         dev_ok = (dev <= DEV_W'(FIRST_DS_DEV_MAX));
      end else begin
         dev_ok = 1'b1;
      end
   end

   assign is_local = (bus == BUS_W'(LOCAL_BUS));
   assign cfg_type = (bus <= BUS_W'(NEAR_LAST_BUS)) ? TYPE_W'(TYPE_NEAR) : TYPE_W'(TYPE_FAR);
   assign target   = is_local ? '0 : packed_tgt;
   assign off_al   = off & ~LOW_MASK;

endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq
   import cfgx_pkg::*;
#(
   parameter int OFF_W  = 12,
   parameter int DATA_W = 32,
   parameter int TGT_W  = 32,
   parameter int TYPE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              dec_ok,
   input  logic              dec_local,
   input  logic [TYPE_W-1:0] dec_type,
   input  logic [TGT_W-1:0]  dec_target,
   input  logic [OFF_W-1:0]  dec_off,
   output logic              acc_valid,
   output logic              acc_local,
   output logic [TYPE_W-1:0] acc_type,
   output logic [TGT_W-1:0]  acc_target,
   output logic [OFF_W-1:0]  acc_offset,
   output logic              acc_write,
   output logic [DATA_W-1:0] acc_wdata,
   input  logic              acc_done,
   input  logic [DATA_W-1:0] acc_rdata,
   input  logic              acc_abort,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err
);

   cfgx_state_e state;

   assign req_ready = (state == CX_IDLE);
   assign acc_valid = (state == CX_WAIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= CX_IDLE;
         acc_local  <= 1'b0;
         acc_type   <= '0;
         acc_target <= '0;
         acc_offset <= '0;
         acc_write  <= 1'b0;
         acc_wdata  <= '0;
         rsp_valid  <= 1'b0;
         rsp_rdata  <= '0;
         rsp_err    <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         case (state)
            CX_IDLE: begin
               if (req_valid) begin
                  if (dec_ok) begin
                     acc_local  <= dec_local;
                     acc_type   <= dec_type;
                     acc_target <= dec_target;
                     acc_offset <= dec_off;
                     acc_write  <= req_write;
                     acc_wdata  <= req_wdata;
                     state      <= CX_WAIT;
                  end else begin
                     rsp_valid <= 1'b1;
                     rsp_rdata <= req_write ? '0 : '1;
                     rsp_err   <= req_write;
                     state     <= CX_RESP;
                  end
               end
            end
            CX_WAIT: begin
               if (acc_done) begin
                  rsp_valid <= 1'b1;
                  if (acc_write) begin
                     rsp_rdata <= '0;
                  end else begin
                     rsp_rdata <= acc_abort ? '1 : acc_rdata;
                  end
                  rsp_err <= acc_write & acc_abort;
                  state   <= CX_RESP;
               end
            end
            default: state <= CX_IDLE;
         endcase
      end
   end

   a_r2_rsp_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r2_no_accept_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> !req_ready);

   a_r9_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_done) |=> (acc_valid && $stable(acc_target)
                                    && $stable(acc_offset) && $stable(acc_type)));

   a_r7_filtered_read: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !dec_ok && !req_write) |=>
         (!acc_valid && rsp_valid && (rsp_rdata == '1) && !rsp_err));

   a_r8_filtered_write: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !dec_ok && req_write) |=>
         (!acc_valid && rsp_valid && rsp_err));

   a_r10_abort_read: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_done && acc_abort && !acc_write) |=>
         (rsp_valid && (rsp_rdata == '1) && !rsp_err));

endmodule

// File: rtl/cfgx_xlate.sv
module cfgx_xlate #(
   parameter int BUS_W            = 8,
   parameter int DEV_W            = 5,
   parameter int FUNC_W           = 3,
   parameter int OFF_W            = 12,
   parameter int DATA_W           = 32,
   parameter int TGT_W            = 32,
   parameter int ALIGN            = 2,
   parameter int TYPE_W           = 3,
   parameter int TYPE_NEAR        = 4,
   parameter int TYPE_FAR         = 5,
   parameter int LOCAL_BUS        = 0,
   parameter int NEAR_LAST_BUS    = 1,
   parameter int LOCAL_DEV_MAX    = 1,
   parameter int FIRST_DS_DEV_MAX = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [BUS_W-1:0]  req_bus,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic [FUNC_W-1:0] req_func,
   input  logic [OFF_W-1:0]  req_offset,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              acc_valid,
   output logic              acc_local,
   output logic [TYPE_W-1:0] acc_type,
   output logic [TGT_W-1:0]  acc_target,
   output logic [OFF_W-1:0]  acc_offset,
   output logic              acc_write,
   output logic [DATA_W-1:0] acc_wdata,
   input  logic              acc_done,
   input  logic [DATA_W-1:0] acc_rdata,
   input  logic              acc_abort,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err
);

   localparam int BDF_W = BUS_W + DEV_W + FUNC_W;

   generate
      if (TGT_W < BDF_W) begin : g_chk_tgt
         $error("target word narrower than bus/device/function");
      end
      if (ALIGN >= OFF_W) begin : g_chk_align
         $error("alignment consumes whole offset");
      end
      if ((TYPE_NEAR >= (1 << TYPE_W)) || (TYPE_FAR >= (1 << TYPE_W))) begin : g_chk_type
         $error("type code does not fit type field");
      end
      if (NEAR_LAST_BUS < LOCAL_BUS) begin : g_chk_near
         $error("near-bus range must include the local bus");
      end
   endgenerate

   logic              d_ok;
   logic              d_local;
   logic [TYPE_W-1:0] d_type;
   logic [TGT_W-1:0]  d_target;
   logic [OFF_W-1:0]  d_off;

   cfgx_decode #(
      .BUS_W(BUS_W), .DEV_W(DEV_W), .FUNC_W(FUNC_W), .OFF_W(OFF_W),
      .TGT_W(TGT_W), .ALIGN(ALIGN), .TYPE_W(TYPE_W),
      .TYPE_NEAR(TYPE_NEAR), .TYPE_FAR(TYPE_FAR), .LOCAL_BUS(LOCAL_BUS),
      .NEAR_LAST_BUS(NEAR_LAST_BUS), .LOCAL_DEV_MAX(LOCAL_DEV_MAX),
      .FIRST_DS_DEV_MAX(FIRST_DS_DEV_MAX)
   ) decode_i (
      .bus      (req_bus),
      .dev      (req_dev),
      .func     (req_func),
      .off      (req_offset),
      .dev_ok   (d_ok),
      .is_local (d_local),
      .cfg_type (d_type),
      .target   (d_target),
      .off_al   (d_off)
   );

   cfgx_seq #(
      .OFF_W(OFF_W), .DATA_W(DATA_W), .TGT_W(TGT_W), .TYPE_W(TYPE_W)
   ) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_write  (req_write),
      .req_wdata  (req_wdata),
      .dec_ok     (d_ok),
      .dec_local  (d_local),
      .dec_type   (d_type),
      .dec_target (d_target),
      .dec_off    (d_off),
      .acc_valid  (acc_valid),
      .acc_local  (acc_local),
      .acc_type   (acc_type),
      .acc_target (acc_target),
      .acc_offset (acc_offset),
      .acc_write  (acc_write),
      .acc_wdata  (acc_wdata),
      .acc_done   (acc_done),
      .acc_rdata  (acc_rdata),
      .acc_abort  (acc_abort),
      .rsp_valid  (rsp_valid),
      .rsp_rdata  (rsp_rdata),
      .rsp_err    (rsp_err)
   );

   a_r3_type_code: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> ((acc_type == TYPE_W'(TYPE_NEAR)) || (acc_type == TYPE_W'(TYPE_FAR))));

   a_r4_local_target_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_local) |-> (acc_target == '0));

   a_r5_offset_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> ((acc_offset & ((OFF_W'(1) << ALIGN) - OFF_W'(1))) == '0));

endmodule

// File: tb/cfgx_xlate_tb_top.sv
module cfgx_xlate_tb_top;

   typedef struct {
      bit          loc;
      logic [2:0]  typ;
      logic [31:0] tgt;
      logic [11:0] off;
      bit          wr;
      logic [31:0] wdata;
      logic [31:0] rdata;
      bit          abort;
      int          delay;
   } acc_item_t;

   typedef struct {
      logic [31:0] data;
      bit          err;
      int          cyc;
   } rsp_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [7:0]  req_bus = '0;
   logic [4:0]  req_dev = '0;
   logic [2:0]  req_func = '0;
   logic [11:0] req_offset = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        acc_valid, acc_local, acc_write;
   logic [2:0]  acc_type;
   logic [31:0] acc_target, acc_wdata;
   logic [11:0] acc_offset;
   logic        acc_done = 1'b0;
   logic [31:0] acc_rdata = '0;
   logic        acc_abort = 1'b0;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   acc_item_t acc_q[$];
   rsp_item_t rsp_q[$];
   acc_item_t cur;
   bit  rem_busy = 1'b0;
   int  rem_cnt = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cfgx_xlate dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
      .req_offset(req_offset), .req_write(req_write), .req_wdata(req_wdata),
      .acc_valid(acc_valid), .acc_local(acc_local), .acc_type(acc_type),
      .acc_target(acc_target), .acc_offset(acc_offset),
      .acc_write(acc_write), .acc_wdata(acc_wdata),
      .acc_done(acc_done), .acc_rdata(acc_rdata), .acc_abort(acc_abort),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic bit exp_ok(input logic [7:0] b, input logic [4:0] d);
      if (b == 0) return d < 2;
      if (b == 1) return d == 0;
      return 1'b1;
   endfunction

   // Transport model: checks each access (R3 R4 R5 R9 R11) and completes it.
   always @(negedge clk) begin
      if (rst_n) begin
         acc_done  = 1'b0;
         acc_abort = 1'b0;
         if (acc_valid) begin
            chk(!req_ready, "R2", "ready while access pending", 32'(req_ready), 0);
            if (!rem_busy) begin
               if (acc_q.size() == 0) begin
                  chk(0, "R7/R8", "unexpected access", acc_target, 0);
               end else begin
                  cur = acc_q.pop_front();
                  rem_busy = 1'b1;
                  rem_cnt = 0;
                  chk(acc_type == cur.typ, "R3", "type", 32'(acc_type), 32'(cur.typ));
                  chk(acc_local == cur.loc, "R4", "local", 32'(acc_local), 32'(cur.loc));
                  chk(acc_target == cur.tgt, "R4", "target", acc_target, cur.tgt);
                  chk(acc_offset == cur.off, "R5", "offset", 32'(acc_offset), 32'(cur.off));
                  chk(acc_write == cur.wr, "R11", "direction", 32'(acc_write), 32'(cur.wr));
                  if (cur.wr)
                     chk(acc_wdata == cur.wdata, "R11", "wdata", acc_wdata, cur.wdata);
               end
            end
            if (rem_busy) begin
               if (rem_cnt == cur.delay) begin
                  chk(acc_target == cur.tgt, "R9", "target held", acc_target, cur.tgt);
                  chk(acc_offset == cur.off, "R9", "offset held", 32'(acc_offset), 32'(cur.off));
                  acc_done  = 1'b1;
                  acc_rdata = cur.rdata;
                  acc_abort = cur.abort;
                  rem_busy  = 1'b0;
               end else begin
                  rem_cnt++;
               end
            end
         end
      end
   end

   // Response monitor: data, error and due cycle (R2 R7 R8 R9 R10).
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (rsp_q.size() == 0) begin
            chk(0, "R2", "extra response", rsp_rdata, 0);
         end else begin
            rsp_item_t e;
            e = rsp_q.pop_front();
            chk(cyc == e.cyc, "R2/R7/R9", "response cycle", 32'(cyc), 32'(e.cyc));
            chk(rsp_rdata == e.data, "R7/R9/R10", "response data", rsp_rdata, e.data);
            chk(rsp_err == e.err, "R8/R10", "response error", 32'(rsp_err), 32'(e.err));
         end
      end
   end

   task automatic send(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                       input logic [11:0] off, input bit wr, input logic [31:0] wd,
                       input logic [31:0] rd, input bit ab, input int dly);
      acc_item_t a;
      rsp_item_t r;
      bit ok;
      int acc_cyc;
      ok = exp_ok(b, d);
      a.loc   = (b == 0);
      a.typ   = (b < 2) ? 3'd4 : 3'd5;
      a.tgt   = (b == 0) ? 32'h0 : {b, d, f, 16'h0000};
      a.off   = {off[11:2], 2'b00};
      a.wr    = wr;
      a.wdata = wd;
      a.rdata = rd;
      a.abort = ab;
      a.delay = dly;
      if (ok) acc_q.push_back(a);
      @(negedge clk);
      chk(req_ready, "R2", "ready before request", 32'(req_ready), 1);
      req_valid = 1'b1; req_bus = b; req_dev = d; req_func = f;
      req_offset = off; req_write = wr; req_wdata = wd;
      @(posedge clk);
      #1;
      acc_cyc = cyc;
      if (!ok) begin
         r.data = wr ? 32'h0 : 32'hFFFF_FFFF;
         r.err  = wr;
         r.cyc  = acc_cyc;
      end else begin
         r.data = wr ? 32'h0 : (ab ? 32'hFFFF_FFFF : rd);
         r.err  = wr & ab;
         r.cyc  = acc_cyc + 1 + dly;
      end
      rsp_q.push_back(r);
      @(negedge clk);
      req_valid = 1'b0;
      req_wdata = 32'hDEAD_BEEF;
      do begin
         @(negedge clk);
         #1;
      end while (rsp_q.size() != 0 || acc_q.size() != 0 || rem_busy);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 1);
      chk(acc_valid == 1'b0, "R1", "reset acc_valid", 32'(acc_valid), 0);
      chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", 32'(rsp_valid), 0);
      rst_n = 1'b1;
      // R4 local bus, R5 alignment
      send(8'd0, 5'd0, 3'd0, 12'h0A3, 1'b0, 32'h0, 32'h1111_2222, 1'b0, 0);
      send(8'd0, 5'd1, 3'd2, 12'h103, 1'b1, 32'hCAFE_0001, 32'h0, 1'b0, 3);
      // R6 R7 R8 filtered devices
      send(8'd0, 5'd2, 3'd0, 12'h000, 1'b0, 32'h0, 32'h0, 1'b0, 0);
      send(8'd0, 5'd31, 3'd7, 12'h010, 1'b1, 32'h1234_5678, 32'h0, 1'b0, 0);
      send(8'd1, 5'd0, 3'd5, 12'h7FE, 1'b0, 32'h0, 32'hA5A5_0001, 1'b0, 1);
      send(8'd1, 5'd1, 3'd0, 12'h004, 1'b0, 32'h0, 32'h0, 1'b0, 0);
      send(8'd1, 5'd3, 3'd0, 12'h008, 1'b1, 32'h0BAD_0BAD, 32'h0, 1'b0, 0);
      // R3 type-1 buses, R9 delays, R11 write data
      send(8'd2, 5'd7, 3'd3, 12'h044, 1'b1, 32'h5555_AAAA, 32'h0, 1'b0, 2);
      send(8'd255, 5'd31, 3'd7, 12'hFFF, 1'b0, 32'h0, 32'h7654_3210, 1'b0, 5);
      // R10 abort
      send(8'd3, 5'd4, 3'd1, 12'h020, 1'b0, 32'h0, 32'h1357_9BDF, 1'b1, 2);
      send(8'd4, 5'd0, 3'd0, 12'h030, 1'b1, 32'hFACE_FEED, 32'h0, 1'b1, 1);
      send(8'd0, 5'd0, 3'd0, 12'h00C, 1'b0, 32'h0, 32'h2468_ACE0, 1'b1, 0);
      for (int i = 0; i < 16; i++) begin
         send(8'(i * 17), 5'(i * 3), 3'(i), 12'(i * 37), i[0], 32'hC000_0000 + i,
              32'hA000_0000 + i, (i % 5) == 4, i % 4);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule